// File: doc/BRIEF.md
# Serial ADC Burst Capture Controller

This block runs a 12-bit serial analog-to-digital converter through a fixed burst of conversions. It works entirely on the shift clock that the board supplies to the converter, so it never has to make that clock itself. For each conversion it raises a one-clock frame sync pulse and shifts in the returned bit stream. It checks the ready marker that precedes the data, lifts out the twelve data bits and writes them, right-aligned and zero-padded, to a small buffer through a plain write port.

A burst begins with a one-cycle `start` pulse. Frames follow back to back with no gap. Each frame that carries a valid ready marker fills the next buffer slot. After the sixth slot is written, no more frame syncs are issued and a one-cycle `done` pulse is raised. A mode input chooses a 16-clock frame or a 15-clock frame. The block reads this input only when a burst begins.

Top module: `sadc_burst_capture`

## Requirements
- R1: With normal framing (`alt_mode`=0 at start), `fsync` is high for exactly one shift clock and rises every 16 shift clocks during a burst. The first pulse comes in the cycle after `start` is sampled.
- R2: With alternate framing (`alt_mode`=1 at start), `fsync` pulses rise every 15 shift clocks.
- R3: Frame bits are numbered k, where k=0 is the bit sampled on the rising edge that ends the `fsync` cycle, and the bit numbered k is sampled k shift clocks later. Bit k=0 is ignored. Bit k=1 is the ready marker (1 = valid). Bits k=2 to 13 carry data D11 down to D0. All later bits of the frame are ignored.
- R4: `wr_data` holds D11..D0 in bits 11:0 and zero in bits 15:12. The input code 0110_0100_0100 is written as decimal 1604.
- R5: For each valid frame, `wr_en` is high for one cycle. That cycle follows the rising edge that samples the frame's last bit. Valid frames take addresses 0,1,2,3,4,5 in order. Every write except the sixth falls in the same cycle as the next frame's `fsync`.
- R6: A frame whose ready marker is 0 produces no write and uses no address. The next frame begins directly after it.
- R7: After the sixth write, `fsync` stays low. `done` is high for one cycle, in the cycle right after the sixth `wr_en`. The block is then idle and accepts a new `start`.
- R8: `alt_mode` is sampled only when a burst starts. Changing it during a burst does not alter the frame length.
- R9: A `start` pulse during an active burst is ignored. Addresses continue in sequence.
- R10: While `rst` is high at a rising edge, the burst is abandoned, and in the following cycle `fsync`, `wr_en` and `done` are low. No write follows until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock from the board; all logic is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a burst |
| alt_mode | input | 1 | 0 selects the 16-clock frame, 1 the 15-clock frame; sampled at start |
| sdata | input | 1 | Serial data returned by the converter |
| fsync | output | 1 | Conversion-start pulse to the converter |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 3 | Buffer slot 0 to 5 |
| wr_data | output | 16 | Right-justified, zero-filled sample |
| done | output | 1 | One-cycle end-of-burst flag |

## Verification
Two events share a cycle in most frames: the write strobe for one sample and the frame sync that opens the next conversion. Both come from the same edge, which also reloads the bit counter. The bench runs bursts back to back with frames of both lengths, with some frames not ready, with a mode flip during the burst and with a stray start. A scoreboard compares the address and data of every strobe. In the same cycle it checks that sync is present, except after the sixth write, and that the spacing of sync pulses stays at the frame length fixed at start.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
   typedef enum logic {
      FRM_NORMAL = 1'b0,
      FRM_ALT    = 1'b1
   } frame_mode_e;
endpackage

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
   parameter int WORD_W = 16,
   parameter int DATA_W = 12,
   parameter int OUT_W  = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_en,
   input  logic             sdata,
   input  logic             mode_alt,
   output logic             rdy_bit,
   output logic [OUT_W-1:0] sample
);
   localparam int SH_W   = WORD_W - 2;
   localparam int TAIL_N = WORD_W - DATA_W - 2;
   localparam int TAIL_A = TAIL_N - 1;

   generate
      if (TAIL_A < 0) begin : g_bad_word
         $error("sadc_shifter: WORD_W must be at least DATA_W+3");
      end
      if (OUT_W < DATA_W) begin : g_bad_out
         $error("sadc_shifter: OUT_W must be at least DATA_W");
      end
   endgenerate

   logic [SH_W-1:0]   shreg;
   logic [SH_W:0]     word;
   logic [DATA_W-1:0] field;

   always_ff @(posedge clk) begin
      if (rst)           shreg <= '0;
      else if (shift_en) shreg <= {shreg[SH_W-2:0], sdata};
   end

   // Word as seen during the last bit of a frame: the newest bit is not yet stored
   assign word = {shreg, sdata};

   always_comb begin
      if (mode_alt) begin
         rdy_bit = word[TAIL_A + DATA_W];
         field   = word[TAIL_A +: DATA_W];
      end else begin
         rdy_bit = word[TAIL_N + DATA_W];
         field   = word[TAIL_N +: DATA_W];
      end
   end

   generate
      if (OUT_W == DATA_W) begin : g_exact
         assign sample = field;
      end else begin : g_pad
         assign sample = {{(OUT_W-DATA_W){1'b0}}, field};
      end
   endgenerate
endmodule

// File: rtl/sadc_sequencer.sv
module sadc_sequencer
   import sadc_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BURST  = 6,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              alt_mode,
   input  logic              frame_rdy,
   output logic              run,
   output logic              mode_alt,
   output logic              fsync,
   output logic              take,
   output logic [ADDR_W-1:0] slot
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0]  LAST_N = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0]  LAST_A = CNT_W'(WORD_W - 2);
   localparam logic [ADDR_W-1:0] SLOT_END = ADDR_W'(BURST - 1);

   frame_mode_e      mode_q;
   logic [CNT_W-1:0] bit_cnt;
   logic             frame_end;
   logic             last_take;

   assign mode_alt  = (mode_q == FRM_ALT);
   assign frame_end = run && (bit_cnt == (mode_alt ? LAST_A : LAST_N));
   assign take      = frame_end && frame_rdy;
   assign last_take = take && (slot == SLOT_END);

   always_ff @(posedge clk) begin
      if (rst) begin
         run     <= 1'b0;
         bit_cnt <= '0;
         fsync   <= 1'b0;
         slot    <= '0;
         mode_q  <= FRM_NORMAL;
      end else if (!run) begin
         fsync <= 1'b0;
         if (start) begin
            run     <= 1'b1;
            bit_cnt <= '0;
            fsync   <= 1'b1;
            slot    <= '0;
            mode_q  <= frame_mode_e'(alt_mode);
         end
      end else if (frame_end) begin
         bit_cnt <= '0;
         if (last_take) begin
            run   <= 1'b0;
            fsync <= 1'b0;
         end else begin
            fsync <= 1'b1;
            if (take) slot <= slot + 1'b1;
         end
      end else begin
         bit_cnt <= bit_cnt + 1'b1;
         fsync   <= 1'b0;
      end
   end

   // R1
   fsync_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      fsync |=> !fsync);

   // R8
   mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (run && $past(run)) |-> $stable(mode_q));
endmodule

// File: rtl/sadc_wport.sv
module sadc_wport #(
   parameter int OUT_W  = 16,
   parameter int ADDR_W = 3,
   parameter int BURST  = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take,
   input  logic [ADDR_W-1:0] slot,
   input  logic [OUT_W-1:0]  sample,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [OUT_W-1:0]  wr_data,
   output logic              done
);
   localparam logic [ADDR_W-1:0] SLOT_END = ADDR_W'(BURST - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         done    <= 1'b0;
      end else begin
         wr_en <= take;
         done  <= wr_en && (wr_addr == SLOT_END);
         if (take) begin
            wr_addr <= slot;
            wr_data <= sample;
         end
      end
   end

   // R5
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !wr_en);
endmodule

// File: rtl/sadc_burst_capture.sv
module sadc_burst_capture #(
   parameter int WORD_W = 16,
   parameter int DATA_W = 12,
   parameter int OUT_W  = 16,
   parameter int BURST  = 6,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              alt_mode,
   input  logic              sdata,
   output logic              fsync,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [OUT_W-1:0]  wr_data,
   output logic              done
);
   generate
      if (BURST < 1 || $clog2(BURST) > ADDR_W) begin : g_bad_addr
         $error("sadc_burst_capture: ADDR_W too narrow for BURST");
      end
   endgenerate

   logic              run;
   logic              mode_alt;
   logic              rdy_bit;
   logic              take;
   logic [ADDR_W-1:0] slot;
   logic [OUT_W-1:0]  sample;

   sadc_sequencer #(.WORD_W(WORD_W), .BURST(BURST), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst(rst), .start(start), .alt_mode(alt_mode),
      .frame_rdy(rdy_bit), .run(run), .mode_alt(mode_alt),
      .fsync(fsync), .take(take), .slot(slot)
   );

   sadc_shifter #(.WORD_W(WORD_W), .DATA_W(DATA_W), .OUT_W(OUT_W)) u_shift (
      .clk(clk), .rst(rst), .shift_en(run), .sdata(sdata),
      .mode_alt(mode_alt), .rdy_bit(rdy_bit), .sample(sample)
   );

   sadc_wport #(.OUT_W(OUT_W), .ADDR_W(ADDR_W), .BURST(BURST)) u_wport (
      .clk(clk), .rst(rst), .take(take), .slot(slot), .sample(sample),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
   );

   // R5
   wr_sync_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr != ADDR_W'(BURST - 1)) |-> fsync);

   // R7
   done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !wr_en);

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!fsync && !wr_en && !done));
endmodule

// File: tb/sadc_burst_capture_bench.sv
`timescale 1ns/1ps
module sadc_burst_capture_bench;
   typedef struct {bit rdy; bit [11:0] d;} frame_t;
   typedef struct {int addr; int data;} item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        alt_mode = 1'b0;
   logic        sdata = 1'b1;
   logic        fsync, wr_en, done;
   logic [2:0]  wr_addr;
   logic [15:0] wr_data;

   int checks = 0, bad = 0, cyc = 0;
   frame_t frame_q[$];
   item_t  exp_q[$];
   int     next_addr = 0;
   int     exp_len = 16;
   int     mon_prev = -1;
   int     last_wr_cyc = -100;
   int     done_seen = 0;
   bit     idle_expect = 1'b1;
   bit     finished = 1'b0;
   int     kk = 100;
   frame_t cur = '{1'b0, 12'h000};

   sadc_burst_capture u_sadc_burst_capture (
      .clk(clk), .rst(rst), .start(start), .alt_mode(alt_mode), .sdata(sdata),
      .fsync(fsync), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Converter model: restarts its bit index on each frame sync
   always @(negedge clk) begin
      if (fsync) begin
         kk = 0;
         if (frame_q.size() > 0) cur = frame_q.pop_front();
         else cur = '{1'b0, 12'hFFF};
      end else begin
         kk++;
      end
      if (kk == 0)                 sdata = 1'b1;
      else if (kk == 1)            sdata = cur.rdy;
      else if (kk >= 2 && kk <= 13) sdata = cur.d[13 - kk];
      else                         sdata = ~kk[0];
   end

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (!rst) begin
         if (wr_en) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5/R10 unexpected write", int'(wr_addr), -1);
            end else begin
               item_t e;
               e = exp_q.pop_front();
               chk(int'(wr_addr) == e.addr, "R5 write address", int'(wr_addr), e.addr);
               chk(int'(wr_data) == e.data, "R4 write data (R3 field)", int'(wr_data), e.data);
               if (e.addr != 5) chk(fsync == 1'b1, "R5 sync with write", int'(fsync), 1);
            end
            last_wr_cyc = cyc;
         end
         if (fsync) begin
            chk(!idle_expect, "R7 sync while idle", 1, 0);
            if (mon_prev >= 0)
               chk(cyc - mon_prev == exp_len, (exp_len == 16) ? "R1 sync period" : "R2 sync period",
                   cyc - mon_prev, exp_len);
            mon_prev = cyc;
         end
         if (done) begin
            chk(cyc == last_wr_cyc + 1, "R7 done timing", cyc - last_wr_cyc, 1);
            done_seen++;
         end
      end
   end

   task automatic add_frame(input bit rdy, input bit [11:0] d);
      frame_q.push_back('{rdy, d});
      if (rdy) begin
         exp_q.push_back('{next_addr, int'(d)});
         next_addr++;
      end
   endtask

   task automatic burst(input bit alt, input bit flip, input bit stray);
      int d0;
      d0 = done_seen;
      exp_len = alt ? 15 : 16;
      mon_prev = -1;
      idle_expect = 1'b0;
      @(negedge clk);
      alt_mode = alt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(fsync == 1'b1, "R1 first sync after start", int'(fsync), 1);
      if (flip) begin
         repeat (20) @(negedge clk);
         alt_mode = ~alt;   // R8
      end
      if (stray) begin
         repeat (25) @(negedge clk);
         start = 1'b1;      // R9
         @(negedge clk);
         start = 1'b0;
      end
      for (int i = 0; i < 3000 && done_seen == d0; i++) @(negedge clk);
      chk(done_seen == d0 + 1, "R7 done raised once", done_seen - d0, 1);
      chk(exp_q.size() == 0, "R7 all six writes", exp_q.size(), 0);
      idle_expect = 1'b1;
      repeat (2) @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
      repeat (40) @(negedge clk);
      frame_q.delete();
      next_addr = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(fsync == 1'b0 && wr_en == 1'b0 && done == 1'b0, "R10 reset state",
          int'({fsync, wr_en, done}), 0);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      // R3 R4 normal frames, includes 1604 and extremes
      add_frame(1, 12'b0110_0100_0100);
      add_frame(1, 12'hFFF);
      add_frame(1, 12'h000);
      add_frame(1, 12'h800);
      add_frame(1, 12'h001);
      add_frame(1, 12'hA5A);
      burst(1'b0, 1'b0, 1'b0);

      // R2 R6 alternate frames with not-ready frames mixed in
      add_frame(0, 12'h123);
      add_frame(1, 12'h5A5);
      add_frame(1, 12'h0F0);
      add_frame(0, 12'hFFF);
      add_frame(1, 12'h644);
      add_frame(1, 12'h7FF);
      add_frame(1, 12'h002);
      add_frame(1, 12'hC3C);
      burst(1'b1, 1'b0, 1'b0);

      // R8 R9 normal with mode flip and stray start
      for (int i = 0; i < 6; i++) add_frame(1, 12'(i * 421 + 7));
      burst(1'b0, 1'b1, 1'b1);

      // R8 alternate with mode flip
      for (int i = 0; i < 6; i++) add_frame(1, 12'(4095 - i * 333));
      burst(1'b1, 1'b1, 1'b0);

      // R10 reset mid-burst
      for (int i = 0; i < 6; i++) add_frame(1, 12'(i + 100));
      exp_len = 16;
      mon_prev = -1;
      idle_expect = 1'b0;
      alt_mode = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      rst = 1'b1;
      exp_q.delete();
      idle_expect = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(fsync == 1'b0 && wr_en == 1'b0 && done == 1'b0, "R10 reset mid-burst",
          int'({fsync, wr_en, done}), 0);
      repeat (80) @(negedge clk);
      frame_q.delete();
      next_addr = 0;

      // recovery after reset
      add_frame(1, 12'h321);
      add_frame(1, 12'h654);
      add_frame(1, 12'h987);
      add_frame(1, 12'hCBA);
      add_frame(1, 12'hFED);
      add_frame(1, 12'h010);
      burst(1'b0, 1'b0, 1'b0);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         finished = 1'b1;
         checks++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule